// File: doc/BRIEF.md
# MDIO Management Master with Indirect Extended-Register Sequencing

This block is a station-management master for an Ethernet PHY. It divides the host clock down to the management clock (MDC). It drives the shared management data line through a separate output and output-enable pair, and it reads the line back through an input pin. It sends and receives complete Clause 22 frames to one PHY address, which is held in a small programmable register.

A host issues one command at a time: a plain register read, a plain register write, an extended (MMD) register write, or an extended burst read. For the two extended operations the block expands the single request into the control/address/data frame series the PHY expects through its indirect access registers 13 and 14. For a burst it then reads register 14 repeatedly and returns one word per read. Each read word appears on `rd_data` with a one-cycle `rd_valid` strobe. `busy` covers the whole series, and `done` marks its end.

Top module: `mdio_mmd_master`

## Requirements
- R1: `mdc` runs continuously with a period of `MDC_DIV` host clocks (default 40), high for the second half and low for the first half of each period.
- R2: Every frame is 32 ones, start bits 0 then 1, opcode 01 for write or 10 for read, the 5-bit PHY address, the 5-bit register address, turnaround bits 1 then 0 on a write, then 16 data bits sent most significant bit first.
- R3: On a read frame `mdio_oe` is low for the two turnaround bits and the 16 data bits, and the data is taken from `mdio_i` at the rising edges of `mdc` in those 16 bit times, MSB first.
- R4: The PHY address field of every frame comes from a register that is 0 after reset and is loaded from `phy_addr_in` in any cycle in which `phy_addr_we` is high.
- R5: Operation code 0 reads register `cmd_reg[4:0]` (0 to 31) in one frame and returns exactly one word with `rd_valid`.
- R6: Operation code 1 writes `cmd_wdata` to register `cmd_reg[4:0]` in one frame and returns no word.
- R7: Operation code 2 (extended write) sends four write frames in this order: register 13 = device address (bits 15:14 = 00), register 14 = `cmd_reg`, register 13 = 0x4000 | device, register 14 = `cmd_wdata`.
- R8: Operation code 3 (extended burst read) sends the same first two frames, then register 13 = 0x8000 | device, then `cmd_count` reads of register 14 (a count of 0 is taken as 1), and returns one word per read in order.
- R9: `busy` is high from the cycle after a command is accepted until the last frame of its series has finished. `done` is high for exactly one cycle, in the first cycle in which `busy` is low again.
- R10: A command presented while `busy` is high is ignored. It sends no frame and changes no PHY register.
- R11: `mdio_o` changes only in the host clock cycle in which `mdc` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phy_addr_we | input | 1 | Load strobe for the PHY address register |
| phy_addr_in | input | 5 | New PHY address |
| cmd_valid | input | 1 | Command request, accepted when `busy` is low |
| cmd_op | input | 2 | 0 plain read, 1 plain write, 2 extended write, 3 extended burst read |
| cmd_dev | input | 5 | Extended device address |
| cmd_reg | input | 16 | Register index (plain ops use bits 4:0) |
| cmd_wdata | input | 16 | Write data |
| cmd_count | input | CNT_W | Number of words for a burst read |
| busy | output | 1 | Command series in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| rd_valid | output | 1 | One-cycle strobe for each read word |
| rd_data | output | 16 | Read word |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data output value |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data line as seen at the pin |

## Verification
A wrong step counter or operation latch appears at the pins at once, as the wrong register or data value in the very next frame. The PHY model on the line decodes and logs every frame, and it catches such errors within one frame time (64 MDC periods). A misplaced turnaround release or sample point appears either as a drive conflict during the turnaround bits or as a read word shifted by one bit, and this shows on the first read. A wrong burst count or a wrong end-of-series decision appears as an extra or a missing `rd_valid` word, or as a `done` pulse that arrives one frame early or late.

// File: rtl/mdio_mmd_pkg.sv
// Shared types and constants for the management master.
// Assumes one frame format (Clause 22) carries every access.
package mdio_mmd_pkg;

    typedef enum logic [1:0] {
        OP_C22_RD = 2'd0,
        OP_C22_WR = 2'd1,
        OP_MMD_WR = 2'd2,
        OP_MMD_RD = 2'd3
    } mm_op_e;

    // Indirect-access register numbers inside the PHY.
    localparam logic [4:0] RA_MMD_CTL  = 5'd13;
    localparam logic [4:0] RA_MMD_DATA = 5'd14;

    // Function codes placed in bits 15:14 of the control register.
    localparam logic [1:0] FN_ADDR     = 2'b00;
    localparam logic [1:0] FN_DATA     = 2'b01;
    localparam logic [1:0] FN_DATA_INC = 2'b10;

    // Frame geometry, counted in MDC bit times.
    localparam int PRE_BITS   = 32;
    localparam int FRAME_BITS = 64;
    localparam int TA_POS     = 46;
    localparam int DATA_POS   = 48;

    typedef struct packed {
        logic        rd;
        logic [4:0]  ra;
        logic [15:0] dat;
    } frame_req_t;

endpackage

// File: rtl/mdc_gen.sv
// MDC generator: divides the host clock by DIV.
// Gives single-cycle ticks for the rising and falling MDC edges so that
// the frame engine can update in step with the pin. DIV must be even and >= 4.
module mdc_gen #(
    parameter int DIV = 40
) (
    input  logic clk,
    input  logic rst_n,
    output logic mdc_o,
    output logic tick_rise,
    output logic tick_fall
);
    localparam int CW   = $clog2(DIV);
    localparam int HALF = DIV / 2;

    logic [CW-1:0] cnt_q;

    assign tick_rise = (cnt_q == CW'(HALF - 1));
    assign tick_fall = (cnt_q == CW'(DIV - 1));

    // Free-running phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= '0;
        else if (tick_fall) cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end

    // MDC pin register, set and cleared on the ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)         mdc_o <= 1'b0;
        else if (tick_rise) mdc_o <= 1'b1;
        else if (tick_fall) mdc_o <= 1'b0;
    end

    // R1: the two edge ticks never coincide.
    a_r1_tick_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick_rise && tick_fall));

    // R1: MDC rises only one cycle after a rise tick.
    a_r1_rise_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc_o) |-> $past(tick_rise));

endmodule

// File: rtl/mdio_frame_eng.sv
// Frame engine: shifts out one 64-bit management frame.
// Outputs change on the MDC falling tick; read data is sampled on the
// rising tick. Assumes start arrives only while the engine is idle and
// reports the end of the frame with a one-cycle fin pulse.
module mdio_frame_eng
    import mdio_mmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_rise,
    input  logic        tick_fall,
    input  logic        mdc_i,
    input  logic        start,
    input  frame_req_t  req,
    input  logic [4:0]  phy_addr,
    output logic        fin,
    output logic [15:0] rdata,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    typedef enum logic {E_IDLE, E_RUN} eng_st_e;

    eng_st_e                 st_q;
    logic [FRAME_BITS-1:0]   sh_q;
    logic [6:0]              bit_q;
    logic                    rd_q;

    // Frame shifter, pin drivers and read capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= E_IDLE;
            sh_q    <= '0;
            bit_q   <= '0;
            rd_q    <= 1'b0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
            fin     <= 1'b0;
            rdata   <= '0;
        end else begin
            fin <= 1'b0;
            case (st_q)
                E_IDLE: begin
                    if (start) begin
                        sh_q  <= {{PRE_BITS{1'b1}}, 2'b01,
                                  (req.rd ? 2'b10 : 2'b01),
                                  phy_addr, req.ra,
                                  (req.rd ? 2'b11 : 2'b10),
                                  req.dat};
                        bit_q <= '0;
                        rd_q  <= req.rd;
                        st_q  <= E_RUN;
                    end
                end
                default: begin
                    if (tick_fall) begin
                        if (bit_q == 7'(FRAME_BITS)) begin
                            st_q    <= E_IDLE;
                            mdio_o  <= 1'b1;
                            mdio_oe <= 1'b0;
                            fin     <= 1'b1;
                        end else begin
                            mdio_o  <= sh_q[FRAME_BITS-1];
                            mdio_oe <= !(rd_q && (bit_q >= 7'(TA_POS)));
                            sh_q    <= {sh_q[FRAME_BITS-2:0], 1'b1};
                            bit_q   <= bit_q + 7'd1;
                        end
                    end
                    if (tick_rise && rd_q && (bit_q > 7'(DATA_POS))
                        && (bit_q <= 7'(FRAME_BITS)))
                        rdata <= {rdata[14:0], mdio_i};
                end
            endcase
        end
    end

    // R11: the data output only moves together with a falling MDC.
    a_r11_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_o) |-> $fell(mdc_i));

    // R3: line released from the turnaround onwards on a read.
    a_r3_release_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == E_RUN && rd_q && bit_q > 7'(TA_POS)) |-> !mdio_oe);

    // R2: a write frame keeps driving for its whole length.
    a_r2_write_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == E_RUN && !rd_q && bit_q != 7'd0) |-> mdio_oe);

endmodule

// File: rtl/mmd_seq.sv
// Command sequencer: turns one host command into the series of frames
// (plain access, or the indirect control/address/data series through
// registers 13 and 14 with post-increment reads). Assumes the frame
// engine signals each frame end with fr_fin.
module mmd_seq
    import mdio_mmd_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  mm_op_e           cmd_op,
    input  logic [4:0]       cmd_dev,
    input  logic [15:0]      cmd_reg,
    input  logic [15:0]      cmd_wdata,
    input  logic [CNT_W-1:0] cmd_count,
    output logic             fr_start,
    output frame_req_t       fr_req,
    input  logic             fr_fin,
    input  logic [15:0]      fr_rdata,
    output logic             busy,
    output logic             done,
    output logic             rd_valid,
    output logic [15:0]      rd_data
);
    typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} seq_st_e;

    seq_st_e          st_q;
    mm_op_e           op_q;
    logic [4:0]       dev_q;
    logic [15:0]      reg_q;
    logic [15:0]      wd_q;
    logic [CNT_W-1:0] left_q;
    logic [1:0]       step_q;
    logic             last_frame;

    assign busy     = (st_q != S_IDLE);
    assign fr_start = (st_q == S_ISSUE);

    // Frame contents for the current operation and step.
    always_comb begin
        fr_req = '{rd: 1'b0, ra: RA_MMD_CTL, dat: 16'h0000};
        case (op_q)
            OP_C22_RD: fr_req = '{rd: 1'b1, ra: reg_q[4:0], dat: 16'h0000};
            OP_C22_WR: fr_req = '{rd: 1'b0, ra: reg_q[4:0], dat: wd_q};
            default: begin
                case (step_q)
                    2'd0: fr_req = '{rd: 1'b0, ra: RA_MMD_CTL,
                                     dat: {FN_ADDR, 9'd0, dev_q}};
                    2'd1: fr_req = '{rd: 1'b0, ra: RA_MMD_DATA, dat: reg_q};
                    2'd2: fr_req = '{rd: 1'b0, ra: RA_MMD_CTL,
                                     dat: {(op_q == OP_MMD_WR) ? FN_DATA : FN_DATA_INC,
                                           9'd0, dev_q}};
                    default: fr_req = (op_q == OP_MMD_WR)
                        ? '{rd: 1'b0, ra: RA_MMD_DATA, dat: wd_q}
                        : '{rd: 1'b1, ra: RA_MMD_DATA, dat: 16'h0000};
                endcase
            end
        endcase
    end

    // End-of-series decision for the frame in flight.
    always_comb begin
        case (op_q)
            OP_C22_RD, OP_C22_WR: last_frame = 1'b1;
            OP_MMD_WR:            last_frame = (step_q == 2'd3);
            default:              last_frame = (step_q == 2'd3) && (left_q == CNT_W'(1));
        endcase
    end

    // Command latch, step walk and result strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= S_IDLE;
            op_q     <= OP_C22_RD;
            dev_q    <= '0;
            reg_q    <= '0;
            wd_q     <= '0;
            left_q   <= '0;
            step_q   <= '0;
            done     <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            done     <= 1'b0;
            rd_valid <= 1'b0;
            case (st_q)
                S_IDLE: begin
                    if (cmd_valid) begin
                        op_q   <= cmd_op;
                        dev_q  <= cmd_dev;
                        reg_q  <= cmd_reg;
                        wd_q   <= cmd_wdata;
                        left_q <= (cmd_count == '0) ? CNT_W'(1) : cmd_count;
                        step_q <= 2'd0;
                        st_q   <= S_ISSUE;
                    end
                end
                S_ISSUE: st_q <= S_WAIT;
                default: begin
                    if (fr_fin) begin
                        if (fr_req.rd) begin
                            rd_valid <= 1'b1;
                            rd_data  <= fr_rdata;
                        end
                        if (last_frame) begin
                            st_q <= S_IDLE;
                            done <= 1'b1;
                        end else begin
                            if (step_q != 2'd3) step_q <= step_q + 2'd1;
                            else                left_q <= left_q - 1'b1;
                            st_q <= S_ISSUE;
                        end
                    end
                end
            endcase
        end
    end

    // R9: done only appears once busy has dropped.
    a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9: done lasts a single cycle.
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: a word is only presented after a read frame finished.
    a_r8_word_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(fr_fin && fr_req.rd));

    // R10: a request during a series leaves the latched command alone.
    a_r10_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> ($stable(op_q) && $stable(dev_q) && $stable(wd_q)));

endmodule

// File: rtl/mdio_mmd_master.sv
// Top: management master with indirect extended-register sequencing.
// Holds the PHY address register and connects the MDC generator,
// the frame engine and the command sequencer.
module mdio_mmd_master
    import mdio_mmd_pkg::*;
#(
    parameter int MDC_DIV = 40,
    parameter int CNT_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phy_addr_we,
    input  logic [4:0]       phy_addr_in,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [4:0]       cmd_dev,
    input  logic [15:0]      cmd_reg,
    input  logic [15:0]      cmd_wdata,
    input  logic [CNT_W-1:0] cmd_count,
    output logic             busy,
    output logic             done,
    output logic             rd_valid,
    output logic [15:0]      rd_data,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);
    logic       tick_rise, tick_fall;
    logic [4:0] phy_q;
    logic       fr_start, fr_fin;
    frame_req_t fr_req;
    logic [15:0] fr_rdata;

    // PHY address register, reset to 0.
    always_ff @(posedge clk) begin
        if (!rst_n)           phy_q <= '0;
        else if (phy_addr_we) phy_q <= phy_addr_in;
    end

    mdc_gen #(.DIV(MDC_DIV)) u_mdc (
        .clk       (clk),
        .rst_n     (rst_n),
        .mdc_o     (mdc),
        .tick_rise (tick_rise),
        .tick_fall (tick_fall)
    );

    mdio_frame_eng u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_rise (tick_rise),
        .tick_fall (tick_fall),
        .mdc_i     (mdc),
        .start     (fr_start),
        .req       (fr_req),
        .phy_addr  (phy_q),
        .fin       (fr_fin),
        .rdata     (fr_rdata),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    mmd_seq #(.CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (mm_op_e'(cmd_op)),
        .cmd_dev   (cmd_dev),
        .cmd_reg   (cmd_reg),
        .cmd_wdata (cmd_wdata),
        .cmd_count (cmd_count),
        .fr_start  (fr_start),
        .fr_req    (fr_req),
        .fr_fin    (fr_fin),
        .fr_rdata  (fr_rdata),
        .busy      (busy),
        .done      (done),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    // R4: the address register only moves on its load strobe.
    a_r4_phy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !phy_addr_we |=> $stable(phy_q));

endmodule

// File: tb/mdio_mmd_master_tb.sv
`timescale 1ns/1ps
module mdio_mmd_master_tb_top;

    localparam int MDC_DIV  = 40;
    localparam int WD_LIMIT = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phy_addr_we = 1'b0;
    logic [4:0]  phy_addr_in = '0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [4:0]  cmd_dev = '0;
    logic [15:0] cmd_reg = '0;
    logic [15:0] cmd_wdata = '0;
    logic [3:0]  cmd_count = '0;
    logic        busy, done, rd_valid, mdc, mdio_o, mdio_oe;
    logic [15:0] rd_data;
    wire         mdio_line;

    logic phy_en = 1'b0;
    logic phy_o  = 1'b1;
    assign mdio_line = mdio_oe ? mdio_o : (phy_en ? phy_o : 1'b1);

    always #2 clk = ~clk;

    mdio_mmd_master #(.MDC_DIV(MDC_DIV), .CNT_W(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .phy_addr_we(phy_addr_we), .phy_addr_in(phy_addr_in),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_dev(cmd_dev), .cmd_reg(cmd_reg),
        .cmd_wdata(cmd_wdata), .cmd_count(cmd_count), .busy(busy), .done(done),
        .rd_valid(rd_valid), .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_line)
    );

    // ---------------- counters and check helper ----------------
    int n_chk = 0, n_bad = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    // ---------------- PHY model on the management line ----------------
    logic [15:0] regs [0:31];
    logic [15:0] mmd_addr [0:31];
    logic [15:0] mmd_mem [0:31][0:63];
    int          fcount = 0, mdl_err = 0, clash = 0;
    logic        lg_rd  [0:63];
    logic [4:0]  lg_ra  [0:63];
    logic [4:0]  lg_phy [0:63];
    logic [15:0] lg_dat [0:63];

    function automatic logic [15:0] mval(input int d, input int a);
        return {d[4:0], 5'b10101, a[5:0]};
    endfunction

    initial begin
        for (int i = 0; i < 32; i++) begin
            regs[i] = {3'b0, i[4:0], 8'hA5};
            mmd_addr[i] = '0;
            for (int a = 0; a < 64; a++) mmd_mem[i][a] = mval(i, a);
        end
        regs[2] = 16'h0022;
        regs[3] = 16'h1622;
    end

    int          ms = 0, ones = 0, hb = 0, db = 0;
    logic [11:0] hdr;
    logic [17:0] dsh;
    logic [15:0] rval;
    int          rd_req = 0, rd_ack = 0, rc = 0;
    logic [15:0] rd_sh;

    function automatic logic [15:0] model_read(input logic [4:0] ra);
        logic [4:0] d;
        logic [15:0] v;
        d = regs[13][4:0];
        if (ra != 5'd14) return regs[ra];
        if (regs[13][15:14] == 2'b00) return mmd_addr[d];
        v = mmd_mem[d][mmd_addr[d][5:0]];
        if (regs[13][15:14] == 2'b10) mmd_addr[d] = mmd_addr[d] + 16'd1;
        return v;
    endfunction

    task automatic model_write(input logic [4:0] ra, input logic [15:0] v);
        logic [4:0] d;
        d = regs[13][4:0];
        if (ra != 5'd14) regs[ra] = v;
        else if (regs[13][15:14] == 2'b00) mmd_addr[d] = v;
        else begin
            mmd_mem[d][mmd_addr[d][5:0]] = v;
            if (regs[13][15]) mmd_addr[d] = mmd_addr[d] + 16'd1;
        end
    endtask

    // Frame decoder on rising MDC.
    always @(posedge mdc) begin
        if (mdio_oe && phy_en) clash++;
        case (ms)
            0: if (mdio_line) ones++;
               else begin
                   if (ones < 32) mdl_err++;
                   else ms = 1;
                   ones = 0;
               end
            1: if (mdio_line) begin ms = 2; hb = 0; end
               else begin mdl_err++; ms = 0; end
            2: begin
                hdr = {hdr[10:0], mdio_line};
                hb++;
                if (hb == 12) begin
                    db = 0;
                    if (hdr[11:10] == 2'b10) begin
                        rval  = model_read(hdr[4:0]);
                        rd_sh = rval;
                        rd_req++;
                        ms = 4;
                    end else if (hdr[11:10] == 2'b01) ms = 3;
                    else begin mdl_err++; ms = 0; end
                end
            end
            3: begin
                dsh = {dsh[16:0], mdio_line};
                db++;
                if (db == 18) begin
                    if (dsh[17:16] != 2'b10) mdl_err++;
                    model_write(hdr[4:0], dsh[15:0]);
                    lg_rd[fcount % 64] = 1'b0; lg_ra[fcount % 64] = hdr[4:0];
                    lg_phy[fcount % 64] = hdr[9:5]; lg_dat[fcount % 64] = dsh[15:0];
                    fcount++;
                    ms = 0; ones = 0;
                end
            end
            default: begin
                db++;
                if (db == 18) begin
                    lg_rd[fcount % 64] = 1'b1; lg_ra[fcount % 64] = hdr[4:0];
                    lg_phy[fcount % 64] = hdr[9:5]; lg_dat[fcount % 64] = rval;
                    fcount++;
                    ms = 0; ones = 0;
                end
            end
        endcase
    end

    // Read data driver on falling MDC.
    always @(negedge mdc) begin
        if (rd_req != rd_ack) begin
            rc++;
            if (rc == 1) phy_en = 1'b0;
            else if (rc == 2) begin phy_en = 1'b1; phy_o = 1'b0; end
            else if (rc <= 18) begin phy_o = rd_sh[15]; rd_sh = {rd_sh[14:0], 1'b0}; end
            else begin phy_en = 1'b0; phy_o = 1'b1; rc = 0; rd_ack++; end
        end
    end

    // R11 monitor: mdio_o moves only in the cycle where mdc falls.
    int   r11_err = 0;
    logic prv_o = 1'b1, prv_mdc = 1'b0;
    always @(negedge clk) begin
        if (rst_n && (mdio_o !== prv_o) && !(prv_mdc && !mdc)) r11_err++;
        prv_o = mdio_o;
        prv_mdc = mdc;
    end

    // ---------------- command tasks ----------------
    logic [15:0] got_w [0:15];
    int          nw = 0;
    logic        wd_hit = 1'b0;

    task automatic issue(input logic [1:0] op, input logic [4:0] dev,
                         input logic [15:0] rg, input logic [15:0] wd, input logic [3:0] cnt);
        @(negedge clk);
        cmd_op = op; cmd_dev = dev; cmd_reg = rg; cmd_wdata = wd; cmd_count = cnt;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R9 busy after accept", {31'd0, busy}, 32'd1);
    endtask

    task automatic wait_done();
        logic seen;
        seen = 1'b0;
        nw = 0;
        while (!seen && cyc < WD_LIMIT) begin
            @(negedge clk);
            if (rd_valid) begin
                if (nw < 16) got_w[nw] = rd_data;
                nw++;
            end
            if (done) begin
                seen = 1'b1;
                chk("R9 busy low with done", {31'd0, busy}, 32'd0);
            end
        end
        @(negedge clk);
        chk("R9 done one cycle", {31'd0, done}, 32'd0);
        if (!seen) wd_hit = 1'b1;
    endtask

    // ---------------- vector table ----------------
    typedef struct packed {
        logic [1:0]  op;
        logic [4:0]  dev;
        logic [15:0] rg;
        logic [15:0] wd;
        logic [3:0]  cnt;
    } vec_t;

    localparam vec_t VEC [0:7] = '{
        '{2'd0, 5'd0, 16'd2,      16'h0000, 4'd0},
        '{2'd0, 5'd0, 16'd3,      16'h0000, 4'd0},
        '{2'd0, 5'd0, 16'd0,      16'h0000, 4'd0},
        '{2'd1, 5'd0, 16'd4,      16'h01E1, 4'd0},
        '{2'd0, 5'd0, 16'd4,      16'h0000, 4'd0},
        '{2'd2, 5'd2, 16'h0008,   16'h01EF, 4'd0},
        '{2'd3, 5'd2, 16'h0007,   16'h0000, 4'd3},
        '{2'd3, 5'd7, 16'h003C,   16'h0000, 4'd4}
    };

    int          s0, nexp, idx;
    logic [4:0]  exp_phy = 5'd0;
    logic [15:0] orig5;
    realtime     t0, t1, t2;

    task automatic check_phy_field(input int from);
        for (int f = from; f < fcount; f++)
            chk("R4 phy field", {27'd0, lg_phy[f % 64]}, {27'd0, exp_phy});
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // Reset state.
        chk("R9 busy in reset", {31'd0, busy}, 32'd0);
        chk("R3 oe in reset", {31'd0, mdio_oe}, 32'd0);
        chk("R2 idle line high", {31'd0, mdio_o}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 done after reset", {30'd0, done, rd_valid}, 32'd0);

        // R1: MDC period and high time.
        @(posedge mdc) t0 = $realtime;
        @(negedge mdc) t1 = $realtime;
        @(posedge mdc) t2 = $realtime;
        chk("R1 mdc period ns", int'(t2 - t0), MDC_DIV * 4);
        chk("R1 mdc high ns", int'(t1 - t0), MDC_DIV * 2);

        // Table walk.
        for (int v = 0; v < 8; v++) begin
            s0 = fcount;
            issue(VEC[v].op, VEC[v].dev, VEC[v].rg, VEC[v].wd, VEC[v].cnt);
            wait_done();
            check_phy_field(s0);
            case (VEC[v].op)
                2'd0: begin
                    chk("R5 frame count", fcount - s0, 1);
                    chk("R5 word count", nw, 1);
                    chk("R5 read data", {16'd0, got_w[0]}, {16'd0, regs[VEC[v].rg[4:0]]});
                    chk("R3 read frame", {31'd0, lg_rd[s0 % 64]}, 32'd1);
                end
                2'd1: begin
                    chk("R6 frame count", fcount - s0, 1);
                    chk("R6 no word", nw, 0);
                    chk("R6 stored value", {16'd0, regs[VEC[v].rg[4:0]]}, {16'd0, VEC[v].wd});
                end
                2'd2: begin
                    chk("R7 frame count", fcount - s0, 4);
                    for (int k = 0; k < 4; k++) begin
                        idx = (s0 + k) % 64;
                        chk("R7 frame is write", {31'd0, lg_rd[idx]}, 32'd0);
                        chk("R7 register order", {27'd0, lg_ra[idx]}, (k % 2 == 0) ? 32'd13 : 32'd14);
                    end
                    chk("R7 ctl addr fn", {16'd0, lg_dat[s0 % 64]}, {27'd0, VEC[v].dev});
                    chk("R7 index", {16'd0, lg_dat[(s0 + 1) % 64]}, {16'd0, VEC[v].rg});
                    chk("R7 ctl data fn", {16'd0, lg_dat[(s0 + 2) % 64]}, 32'h4000 | {27'd0, VEC[v].dev});
                    chk("R7 data", {16'd0, lg_dat[(s0 + 3) % 64]}, {16'd0, VEC[v].wd});
                    chk("R7 stored", {16'd0, mmd_mem[VEC[v].dev][VEC[v].rg[5:0]]}, {16'd0, VEC[v].wd});
                end
                default: begin
                    nexp = (VEC[v].cnt == 0) ? 1 : int'(VEC[v].cnt);
                    chk("R8 frame count", fcount - s0, 3 + nexp);
                    chk("R8 word count", nw, nexp);
                    chk("R8 ctl incr fn", {16'd0, lg_dat[(s0 + 2) % 64]}, 32'h8000 | {27'd0, VEC[v].dev});
                    for (int k = 0; k < nexp; k++) begin
                        chk("R8 read register", {27'd0, lg_ra[(s0 + 3 + k) % 64]}, 32'd14);
                        chk("R8 burst word", {16'd0, got_w[k % 16]},
                            {16'd0, mmd_mem[VEC[v].dev][(VEC[v].rg[5:0] + k) % 64]});
                    end
                end
            endcase
        end

        // R4: new PHY address, boundary register 31.
        @(negedge clk);
        phy_addr_in = 5'd5; phy_addr_we = 1'b1;
        @(negedge clk);
        phy_addr_we = 1'b0; exp_phy = 5'd5;
        s0 = fcount;
        issue(2'd0, 5'd0, 16'd31, 16'h0, 4'd0);
        wait_done();
        check_phy_field(s0);
        chk("R5 register 31", {16'd0, got_w[0]}, {16'd0, regs[31]});

        // R8: count of zero gives one word.
        s0 = fcount;
        issue(2'd3, 5'd3, 16'h0005, 16'h0, 4'd0);
        wait_done();
        chk("R8 zero count words", nw, 1);
        chk("R8 zero count frames", fcount - s0, 4);
        chk("R8 zero count data", {16'd0, got_w[0]}, {16'd0, mmd_mem[3][5]});

        // R10: request while busy is dropped.
        orig5 = regs[5];
        s0 = fcount;
        issue(2'd0, 5'd0, 16'd2, 16'h0, 4'd0);
        repeat (10) @(negedge clk);
        cmd_op = 2'd1; cmd_reg = 16'd5; cmd_wdata = 16'hDEAD; cmd_valid = 1'b1;
        repeat (3) @(negedge clk);
        cmd_valid = 1'b0;
        wait_done();
        chk("R10 single frame", fcount - s0, 1);
        chk("R10 first result kept", {16'd0, got_w[0]}, {16'd0, regs[2]});
        issue(2'd0, 5'd0, 16'd5, 16'h0, 4'd0);
        wait_done();
        chk("R10 register untouched", {16'd0, got_w[0]}, {16'd0, orig5});

        // Line-level protocol tallies.
        chk("R2 malformed frames", mdl_err, 0);
        chk("R3 drive conflicts", clash, 0);
        chk("R11 off-edge output moves", r11_err, 0);
        if (wd_hit || cyc >= WD_LIMIT) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WD_LIMIT);
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule